// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block is a target on a two-wire serial bus. It gives a controller byte access to a 20-location register space at addresses 00h to 13h. It oversamples the bus clock and data lines with the system clock and finds START and STOP conditions. It compares the address byte with its fixed 7-bit address. In a write, the first byte after the address becomes the register pointer. Every later byte goes out on a single-cycle register-file write strobe at the pointed location, and the pointer then steps forward. A read starts at the current pointer and sends bytes MSB first. The pointer advances only when the controller acknowledges a byte.

The bus side has no back-pressure. Clock stretching is out of scope, so each byte moves at the controller's pace. The register file must accept the write strobe in the cycle it appears. It must also return read data combinationally for the address presented on `reg_addr`. The data line is driven only through an active-high pull-low enable. A power-fail input aborts any transfer and clears the pointer. A status output tells the timekeeping logic when a transfer is touching the clock registers (00h to 07h).

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges only address bytes D0h (write) and D1h (read), i.e. 7-bit address 68h with R/W in bit 0. It pulls SDA low during the ninth clock of a matching byte and leaves SDA released for any other address.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A START inside a transfer (repeated START) restarts address matching.
- R3: In a write transfer, the first byte after the address is loaded into the pointer and acknowledged. A pointer value of 14h or above loads 00h.
- R4: Each later write byte is acknowledged and causes exactly one one-cycle `reg_wr_en` pulse at `reg_addr` equal to the pointer. The pointer then increments on that byte's acknowledge clock.
- R5: Read bytes are sent MSB first. The pointer increments only when the controller acknowledges (SDA low on the ninth clock). A not-acknowledge ends the burst and leaves SDA released.
- R6: A read addressed with no preceding pointer write starts at the pointer value left by earlier transfers.
- R7: A pointer write followed by a repeated START and a read address reads from the pointer just written.
- R8: `clk_access` is high while the pointer is in 00h to 07h, from the acknowledged address byte until STOP, a new START, a read NACK or power-fail. It is low in the cycle after a STOP is seen.
- R9: The pointer wraps from 13h to 00h. Writes to 10h to 12h are acknowledged but produce no `reg_wr_en`. Reads from them return 00h.
- R10: While `pwr_fail` is high, the transfer is aborted, SDA is released, the pointer becomes 00h and bus activity is ignored (no acknowledge, no write).
- R11: Nothing pending survives a STOP. Bytes clocked after a STOP without a new START are neither acknowledged nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| pwr_fail | input | 1 | Supply out of tolerance; aborts and holds off the bus |
| reg_addr | output | 5 | Register-file address (the pointer) |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Write data |
| reg_rd_data | input | 8 | Combinational read data for `reg_addr` |
| clk_access | output | 1 | A transfer is at a clock-register address |

## Verification
On every cycle, assertions check the following. The pointer never leaves 00h to 13h, and it is cleared and SDA released one cycle after power-fail. The write strobe lasts exactly one cycle and never targets a reserved location. SDA is pulled low only in addressed states and starts being pulled only while SCL is low. `clk_access` drops after a STOP. Only the bench's scenarios can show the rest. These cover the acknowledge pattern for matching and foreign addresses, the byte values sent on reads, and pointer retention across transfers and through NACKs. They also cover the wrap at 13h, the load of an out-of-range pointer, and the refusal of bytes that follow a STOP or arrive during power-fail.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/i2c_bus_front.sv
module i2c_bus_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_c,
  output logic stop_c
);
  logic [1:0] raw, lv, rs, fl;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw[g]),
      .lvl(lv[g]), .rise(rs[g]), .fall(fl[g])
    );
  end

  assign scl_lvl  = lv[0];
  assign scl_rise = rs[0];
  assign scl_fall = fl[0];
  assign sda_lvl  = lv[1];
  // data edges while the clock stays high are bus conditions
  assign start_c  = fl[1] & lv[0] & ~fl[0];
  assign stop_c   = rs[1] & lv[0] & ~fl[0];
endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit #(
  parameter int NREG     = 20,
  parameter int CLK_REGS = 8,
  parameter int RSV_LO   = 16,
  parameter int RSV_HI   = 18
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      load,
  input  logic [7:0]                load_val,
  input  logic                      inc,
  output logic [$clog2(NREG)-1:0]   ptr,
  output logic                      in_clk,
  output logic                      in_rsv
);
  localparam int AW = $clog2(NREG);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    ptr <= '0;
    else if (clr)  ptr <= '0;
    else if (load) ptr <= (32'(load_val) < NREG) ? load_val[AW-1:0] : '0;
    else if (inc)  ptr <= (32'(ptr) == NREG - 1) ? '0 : ptr + 1'b1;

  assign in_clk = 32'(ptr) < CLK_REGS;
  assign in_rsv = (32'(ptr) >= RSV_LO) && (32'(ptr) <= RSV_HI);

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr) < NREG);                                               // R9
  AST_CLR_ZEROES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr == '0);                                             // R10
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         NREG        = 20,
  parameter int         CLK_REGS    = 8,
  parameter int         RSV_LO      = 16,
  parameter int         RSV_HI      = 18,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          pwr_fail,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr_en,
  output logic [7:0]    reg_wr_data,
  input  logic [7:0]    reg_rd_data,
  output logic          clk_access
);
  logic scl_lvl, scl_rise, scl_fall, sda_lvl, start_c, stop_c;
  tgt_state_e st;
  logic [3:0] cnt;
  logic [7:0] sr, rd_byte;
  logic       rw, acked, oe_q;
  logic       in_clk, in_rsv, active, byte_done, ptr_load, ptr_inc;
  logic [AW-1:0] ptr;

  i2c_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_c(start_c), .stop_c(stop_c)
  );

  assign active    = !pwr_fail && !start_c && !stop_c;
  assign byte_done = scl_fall && (cnt == 4'd8);
  assign ptr_load  = active && (st == ST_PTR) && byte_done;
  assign ptr_inc   = active && scl_rise &&
                     ((st == ST_WR_ACK) || (st == ST_RD_ACK && !sda_lvl));

  i2c_ptr_unit #(.NREG(NREG), .CLK_REGS(CLK_REGS), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(pwr_fail), .load(ptr_load), .load_val(sr),
    .inc(ptr_inc), .ptr(ptr), .in_clk(in_clk), .in_rsv(in_rsv)
  );

  assign rd_byte = in_rsv ? 8'h00 : reg_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sr <= '0; rw <= 1'b0; acked <= 1'b0; oe_q <= 1'b0;
    end else if (pwr_fail) begin
      st <= ST_IDLE; cnt <= '0; oe_q <= 1'b0;
    end else if (start_c) begin
      st <= ST_ADDR; cnt <= '0; oe_q <= 1'b0;
    end else if (stop_c) begin
      st <= ST_IDLE; oe_q <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_PTR, ST_WR: begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_lvl};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt  <= '0;
            oe_q <= 1'b1;
            if (st == ST_ADDR) begin
              if (sr[7:1] == DEV_ADDR) begin
                st <= ST_ADDR_ACK;
                rw <= sr[0];
              end else begin
                st   <= ST_IDLE;
                oe_q <= 1'b0;
              end
            end else if (st == ST_PTR) st <= ST_PTR_ACK;
            else                       st <= ST_WR_ACK;
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          if (rw) begin
            st <= ST_RD; sr <= rd_byte; oe_q <= ~rd_byte[7]; cnt <= '0;
          end else begin
            st <= ST_PTR; oe_q <= 1'b0;
          end
        end
        ST_PTR_ACK, ST_WR_ACK: if (scl_fall) begin
          st <= ST_WR; oe_q <= 1'b0;
        end
        ST_RD: if (scl_fall) begin
          if (cnt == 4'd7) begin
            st <= ST_RD_ACK; oe_q <= 1'b0; cnt <= '0;
          end else begin
            sr <= {sr[6:0], 1'b0}; oe_q <= ~sr[6]; cnt <= cnt + 4'd1;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) acked <= ~sda_lvl;
          else if (scl_fall) begin
            if (acked) begin
              st <= ST_RD; sr <= rd_byte; oe_q <= ~rd_byte[7]; cnt <= '0;
            end else st <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe      = oe_q;
  assign reg_addr    = ptr;
  assign reg_wr_data = sr;
  assign reg_wr_en   = active && (st == ST_WR) && byte_done && !in_rsv;
  assign clk_access  = in_clk && (st != ST_IDLE) && (st != ST_ADDR);

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);                                      // R4
  AST_NO_WR_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !(32'(reg_addr) >= RSV_LO && 32'(reg_addr) <= RSV_HI)); // R9
  AST_PF_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !sda_oe);                                          // R10
  AST_STOP_DROPS_CLKACC: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !clk_access);                                        // R8
  AST_PULL_ONLY_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st != ST_IDLE && st != ST_ADDR));                   // R1
  AST_PULL_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);                                    // R2
endmodule

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;
  localparam int Q = 6;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, pwr_fail = 1'b0;
  logic sda_oe, reg_wr_en, clk_access, sda_bus;
  logic [4:0] reg_addr;
  logic [7:0] reg_wr_data, reg_rd_data;
  logic [7:0] rf [0:19];
  logic [7:0] exp_rf [0:19];
  int exp_ptr, wr_count, n_chk, n_bad;
  bit done;

  always #2.5 clk = ~clk;
  assign sda_bus = ~(m_low | sda_oe);

  i2c_reg_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pwr_fail(pwr_fail), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .clk_access(clk_access)
  );

  // register file on the far side of the write/read port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 20; i++) rf[i] <= 8'h40 + 8'(i);
      wr_count <= 0;
    end else if (reg_wr_en) begin
      rf[reg_addr] <= reg_wr_data;
      wr_count <= wr_count + 1;
    end
  end
  assign reg_rd_data = (reg_addr < 5'd20) ? rf[reg_addr] : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put_bit(input bit b);
    m_low = ~b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b0; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit nack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(nack);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~give_ack);
    if (give_ack) exp_ptr = (exp_ptr == 19) ? 0 : exp_ptr + 1;
  endtask

  // model: write a burst at a pointer
  task automatic do_write(input logic [7:0] p, input logic [7:0] d [], input string req);
    bit nk;
    bus_start();
    send_byte(8'hD0, nk); chk(nk == 0, "R1", nk, 0);
    send_byte(p, nk);     chk(nk == 0, "R3", nk, 0);
    exp_ptr = (p < 20) ? int'(p) : 0;
    foreach (d[k]) begin
      send_byte(d[k], nk); chk(nk == 0, req, nk, 0);
      if (!(exp_ptr >= 16 && exp_ptr <= 18)) exp_rf[exp_ptr] = d[k];
      exp_ptr = (exp_ptr == 19) ? 0 : exp_ptr + 1;
    end
    bus_stop();
  endtask

  function automatic logic [7:0] model_rd(input int p);
    return (p >= 16 && p <= 18) ? 8'h00 : exp_rf[p];
  endfunction

  initial begin
    logic [7:0] d;
    bit nk;
    int wc;
    for (int i = 0; i < 20; i++) exp_rf[i] = 8'h40 + 8'(i);
    exp_ptr = 0;
    tick(4); rst_n = 1'b1; tick(4);

    // reset state
    chk(sda_oe == 0 && clk_access == 0 && reg_wr_en == 0, "R1 reset", {sda_oe, clk_access, reg_wr_en}, 0);

    // foreign address is not acknowledged
    bus_start(); send_byte(8'hD2, nk); chk(nk == 1, "R1 foreign addr", nk, 1); bus_stop();

    // pointer write and burst write; clock-range flag
    bus_start();
    send_byte(8'hD0, nk); chk(nk == 0, "R1 write addr", nk, 0);
    send_byte(8'h02, nk); chk(nk == 0, "R3 ptr ack", nk, 0);
    chk(clk_access == 1, "R8 high in clock range", clk_access, 1);
    exp_ptr = 2;
    foreach (exp_rf[k]) if (k >= 2 && k <= 4) begin
      send_byte(8'h11 * 8'(k - 1), nk); chk(nk == 0, "R4 data ack", nk, 0);
      exp_rf[k] = 8'h11 * 8'(k - 1);
    end
    exp_ptr = 5;
    bus_stop();
    chk(clk_access == 0, "R8 low after stop", clk_access, 0);
    for (int k = 2; k <= 4; k++) chk(rf[k] == exp_rf[k], "R4 written value", rf[k], exp_rf[k]);

    // pointer write, repeated start, read burst ending in NACK
    bus_start(); send_byte(8'hD0, nk); send_byte(8'h02, nk); exp_ptr = 2;
    bus_start(); send_byte(8'hD1, nk); chk(nk == 0, "R7 read addr ack", nk, 0);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] e;
      e = model_rd(exp_ptr);
      recv_byte(k < 2, d);
      chk(d == e, "R7 R5 read data", d, e);
    end
    chk(sda_oe == 0, "R5 released after NACK", sda_oe, 0);
    bus_stop();

    // read with no pointer write continues from stored pointer (NACK did not advance)
    bus_start(); send_byte(8'hD1, nk);
    begin logic [7:0] e; e = model_rd(exp_ptr); recv_byte(0, d); chk(d == e, "R6 stored pointer", d, e); end
    bus_stop();

    // wrap and reserved locations
    wc = wr_count;
    do_write(8'h12, '{8'hAA, 8'hBB, 8'hCC}, "R9 data ack");
    chk(wr_count == wc + 2, "R9 reserved write discarded", wr_count, wc + 2);
    chk(rf[19] == 8'hBB && rf[0] == 8'hCC, "R9 wrap write", {rf[19], rf[0]}, 16'hBBCC);
    chk(rf[18] == 8'h52, "R9 reserved untouched", rf[18], 8'h52);
    bus_start(); send_byte(8'hD0, nk); send_byte(8'h12, nk); exp_ptr = 18;
    chk(clk_access == 0, "R8 low outside clock range", clk_access, 0);
    bus_start(); send_byte(8'hD1, nk);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] e;
      e = model_rd(exp_ptr);
      recv_byte(k < 2, d);
      chk(d == e, "R9 reserved/wrap read", d, e);
    end
    bus_stop();

    // out-of-range pointer loads 00h
    bus_start(); send_byte(8'hD0, nk); send_byte(8'h30, nk); bus_stop(); exp_ptr = 0;
    bus_start(); send_byte(8'hD1, nk);
    begin logic [7:0] e; e = model_rd(0); recv_byte(0, d); chk(d == e, "R3 big pointer -> 00h", d, e); end
    bus_stop();

    // power fail mid-transfer
    bus_start(); send_byte(8'hD0, nk); send_byte(8'h05, nk);
    pwr_fail = 1'b1; tick(3);
    chk(sda_oe == 0 && clk_access == 0, "R10 abort", {sda_oe, clk_access}, 0);
    wc = wr_count;
    send_byte(8'h77, nk); chk(nk == 1, "R10 ignored byte", nk, 1);
    bus_stop(); bus_start(); send_byte(8'hD0, nk); chk(nk == 1, "R10 ignored addr", nk, 1);
    bus_stop();
    chk(wr_count == wc, "R10 no write", wr_count, wc);
    pwr_fail = 1'b0; tick(4); exp_ptr = 0;
    bus_start(); send_byte(8'hD1, nk);
    begin logic [7:0] e; e = model_rd(0); recv_byte(0, d); chk(d == e, "R10 pointer cleared", d, e); end
    bus_stop();

    // bytes after STOP without START
    bus_start(); send_byte(8'hD0, nk); send_byte(8'h06, nk); bus_stop();
    wc = wr_count;
    send_byte(8'h99, nk); chk(nk == 1, "R11 no ack after stop", nk, 1);
    send_byte(8'hD0, nk); chk(nk == 1, "R11 addr needs start", nk, 1);
    chk(wr_count == wc && rf[6] == exp_rf[6], "R11 no write after stop", rf[6], exp_rf[6]);
    bus_stop();

    // repeated START restarts address matching
    bus_start(); send_byte(8'hD0, nk); bus_start(); send_byte(8'hD2, nk);
    chk(nk == 1, "R2 restart rematches", nk, 1);
    bus_stop();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule